// File: doc/BRIEF.md
# Store Path with Fault Reporting

This block carries out one store at a time against a simple memory write port. It takes a base register value, a 12-bit signed immediate, the source register value, a width code and three ordering flags (acquire, release, conditional). From these it forms the effective address, picks the low bytes of the source for the write, and classifies the flags into a request kind that travels with the write.

Before anything reaches memory, the block checks alignment for release and conditional stores. It also rejects the unsupported acquire-without-release combination. A misaligned ordered store, or a write that the memory port answers with an error, becomes a trap. The trap carries a store exception code, the faulting effective address and the redirect target of the trap handler. A plain store is sent to memory whatever its alignment. A store that completes without error gives a one-cycle completion pulse.

Top module: `store_fault_unit`

## Requirements
- R1: The memory address equals the base value plus the 12-bit immediate sign-extended to 64 bits.
- R2: The width code selects the store size: 0 byte, 1 halfword, 2 word, 3 doubleword. The write data is the low 8/16/32/64 bits of the source with the upper bits zero, and the width code is forwarded unchanged as the write size.
- R3: The request kind is coded as follows, with acquire, release and conditional named as flags. 0 is plain (no flags). 1 is release (release only). 2 is strong-release (acquire and release). 3 is conditional (conditional only). 4 is conditional-release (conditional and release). 5 is conditional-strong-release (all three flags).
- R4: When release or conditional is set and the address is not a multiple of the access size, no write is issued. Instead the block pulses a trap with cause 6 (store address misaligned) and trap value equal to the effective address. This check takes priority over R6.
- R5: A plain store (no flags) with a misaligned address is issued to memory unchanged and completes normally.
- R6: Acquire set with release clear pulses the unsupported output for one cycle. No write is issued and no trap is raised.
- R7: When the memory port accepts the write with its error bit set, the block pulses a trap with cause 7 (store access fault) and trap value equal to the effective address.
- R8: Once raised, the write request holds its valid, address, data, size and kind unchanged until memory asserts ready.
- R9: A write accepted without error gives a one-cycle completion pulse. Whenever the trap pulse is high, the redirect output holds the trap handler address.
- R10: After reset the block is ready for a new store, no write is pending, and the trap, completion and unsupported outputs are low.
- R11: While a write is pending, the block does not accept a new store. At most one of trap, completion and unsupported is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid_i | input | 1 | A store operation is presented |
| op_ready_o | output | 1 | Block can take a store this cycle |
| base_i | input | 64 | Base register value |
| imm_i | input | 12 | Signed immediate offset |
| src_i | input | 64 | Source register value |
| width_i | input | 2 | Size code (0 byte .. 3 doubleword) |
| acq_i | input | 1 | Acquire ordering flag |
| rel_i | input | 1 | Release ordering flag |
| cond_i | input | 1 | Conditional store flag |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory accepts the write |
| wr_err_i | input | 1 | Memory rejects the write (sampled with ready) |
| wr_addr_o | output | 64 | Write address |
| wr_data_o | output | 64 | Write data, zero above the size |
| wr_size_o | output | 2 | Write size code |
| wr_kind_o | output | 3 | Request kind |
| trap_o | output | 1 | Trap pulse |
| trap_cause_o | output | 5 | Exception code (6 misaligned, 7 access fault) |
| trap_tval_o | output | 64 | Faulting effective address |
| redirect_pc_o | output | 64 | Trap handler address for the next PC |
| done_o | output | 1 | Store completed pulse |
| unsup_o | output | 1 | Unsupported flag combination pulse |

## Verification
The properties assume that memory drives its error bit only together with ready, and asserts ready only while a write is pending. The bench's memory model raises ready only after a write appears, and always clears both bits on the following cycle. The properties also assume that the operation inputs are presented only while the block reports ready. The stimulus drops the operation valid right after each accept edge and waits for the result before the next store. Memory stalls of several cycles are inserted on every write, so that the hold rule is exercised.

// File: rtl/store_fault_unit.sv
module store_fault_unit #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] TRAP_VEC = 64'h0000_0000_0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid_i,
  output logic            op_ready_o,
  input  logic [XLEN-1:0] base_i,
  input  logic [11:0]     imm_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [1:0]      width_i,
  input  logic            acq_i,
  input  logic            rel_i,
  input  logic            cond_i,
  output logic            wr_valid_o,
  input  logic            wr_ready_i,
  input  logic            wr_err_i,
  output logic [XLEN-1:0] wr_addr_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic [1:0]      wr_size_o,
  output logic [2:0]      wr_kind_o,
  output logic            trap_o,
  output logic [4:0]      trap_cause_o,
  output logic [XLEN-1:0] trap_tval_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            done_o,
  output logic            unsup_o
);
  localparam int IMM_W = 12;
  localparam logic [4:0] CAUSE_MISALIGN = 5'd6;
  localparam logic [4:0] CAUSE_ACCESS   = 5'd7;

  typedef enum logic {S_IDLE, S_ISSUE} state_t;
  state_t state;

  logic [XLEN-1:0] ea;
  logic [XLEN-1:0] data_sel;
  logic            misaligned;
  logic            need_align;
  logic [2:0]      kind;

  assign ea         = base_i + {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign need_align = rel_i | cond_i;
  assign op_ready_o = (state == S_IDLE);
  assign redirect_pc_o = TRAP_VEC;

  always_comb begin
    case (width_i)
      2'd0:    misaligned = 1'b0;
      2'd1:    misaligned = ea[0];
      2'd2:    misaligned = |ea[1:0];
      default: misaligned = |ea[2:0];
    endcase
  end

  always_comb begin
    data_sel = '0;
    case (width_i)
      2'd0:    data_sel[7:0]  = src_i[7:0];
      2'd1:    data_sel[15:0] = src_i[15:0];
      2'd2:    data_sel[31:0] = src_i[31:0];
      default: data_sel       = src_i;
    endcase
  end

  always_comb begin
    case ({cond_i, acq_i, rel_i})
      3'b001:  kind = 3'd1;
      3'b011:  kind = 3'd2;
      3'b100:  kind = 3'd3;
      3'b101:  kind = 3'd4;
      3'b111:  kind = 3'd5;
      default: kind = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      wr_valid_o   <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      wr_size_o    <= '0;
      wr_kind_o    <= '0;
      trap_o       <= 1'b0;
      trap_cause_o <= '0;
      trap_tval_o  <= '0;
      done_o       <= 1'b0;
      unsup_o      <= 1'b0;
    end else begin
      trap_o  <= 1'b0;
      done_o  <= 1'b0;
      unsup_o <= 1'b0;
      case (state)
        S_IDLE: if (op_valid_i) begin
          if (need_align && misaligned) begin
            trap_o       <= 1'b1;
            trap_cause_o <= CAUSE_MISALIGN;
            trap_tval_o  <= ea;
          end else if (acq_i && !rel_i) begin
            unsup_o <= 1'b1;
          end else begin
            wr_valid_o <= 1'b1;
            wr_addr_o  <= ea;
            wr_data_o  <= data_sel;
            wr_size_o  <= width_i;
            wr_kind_o  <= kind;
            state      <= S_ISSUE;
          end
        end
        default: if (wr_ready_i) begin
          wr_valid_o <= 1'b0;
          state      <= S_IDLE;
          if (wr_err_i) begin
            trap_o       <= 1'b1;
            trap_cause_o <= CAUSE_ACCESS;
            trap_tval_o  <= wr_addr_o;
          end else begin
            done_o <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/store_fault_unit_chk.sv
module store_fault_unit_chk #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] TRAP_VEC = 64'h0000_0000_0000_0100
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_ready_o,
  input logic            wr_valid_o,
  input logic            wr_ready_i,
  input logic            wr_err_i,
  input logic [XLEN-1:0] wr_addr_o,
  input logic [XLEN-1:0] wr_data_o,
  input logic [1:0]      wr_size_o,
  input logic [2:0]      wr_kind_o,
  input logic            trap_o,
  input logic [4:0]      trap_cause_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            done_o,
  input logic            unsup_o
);
  logic addr_ok;
  always_comb begin
    case (wr_size_o)
      2'd0:    addr_ok = 1'b1;
      2'd1:    addr_ok = !wr_addr_o[0];
      2'd2:    addr_ok = wr_addr_o[1:0] == 2'b00;
      default: addr_ok = wr_addr_o[2:0] == 3'b000;
    endcase
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) &&
      $stable(wr_data_o) && $stable(wr_size_o) && $stable(wr_kind_o)));

  // R4
  ordered_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_kind_o != 3'd0) |-> addr_ok);

  // R7
  access_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && wr_err_i) |=> (trap_o && trap_cause_o == 5'd7));

  // R9
  done_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && !wr_err_i) |=> (done_o && !trap_o));

  // R9
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (redirect_pc_o == TRAP_VEC));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> !op_ready_o);

  // R11
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_o, done_o, unsup_o}));
endmodule

bind store_fault_unit store_fault_unit_chk #(.XLEN(XLEN), .TRAP_VEC(TRAP_VEC)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_ready_o(op_ready_o), .wr_valid_o(wr_valid_o),
  .wr_ready_i(wr_ready_i), .wr_err_i(wr_err_i), .wr_addr_o(wr_addr_o),
  .wr_data_o(wr_data_o), .wr_size_o(wr_size_o), .wr_kind_o(wr_kind_o),
  .trap_o(trap_o), .trap_cause_o(trap_cause_o), .redirect_pc_o(redirect_pc_o),
  .done_o(done_o), .unsup_o(unsup_o)
);

// File: tb/store_fault_unit_tb_top.sv
`timescale 1ns/1ps
module store_fault_unit_tb_top;
  localparam logic [63:0] TVEC = 64'h0000_0000_0000_0100;
  localparam int NV = 12;
  localparam logic [1:0] O_DONE = 2'd0, O_MIS = 2'd1, O_ACC = 2'd2, O_UNS = 2'd3;

  typedef struct packed {
    logic [63:0] base;
    logic [11:0] imm;
    logic [63:0] src;
    logic [1:0]  w;
    logic        acq, rel, cond, merr;
    logic [1:0]  outc;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{64'h1000, 12'h008, 64'h1122334455667788, 2'd3, 1'b0,1'b0,1'b0,1'b0, 2'd0},
    '{64'h2000, 12'hFFC, 64'hCAFEBABE_DEADBEEF, 2'd2, 1'b0,1'b1,1'b0,1'b0, 2'd0},
    '{64'h3001, 12'h000, 64'h0000_0000_0000_ABCD, 2'd1, 1'b0,1'b1,1'b0,1'b0, 2'd1},
    '{64'h3001, 12'h000, 64'hFFFF_FFFF_1234_5678, 2'd2, 1'b0,1'b0,1'b0,1'b0, 2'd0},
    '{64'h4000, 12'h7FF, 64'h0123_4567_89AB_CDEF, 2'd0, 1'b0,1'b0,1'b1,1'b0, 2'd0},
    '{64'h5004, 12'h000, 64'h5555_5555_5555_5555, 2'd3, 1'b0,1'b1,1'b1,1'b0, 2'd1},
    '{64'h5008, 12'h800, 64'hA5A5_A5A5_A5A5_A5A5, 2'd3, 1'b1,1'b1,1'b1,1'b0, 2'd0},
    '{64'h6000, 12'h000, 64'h0F0F_0F0F_0F0F_0F0F, 2'd3, 1'b1,1'b1,1'b0,1'b1, 2'd2},
    '{64'h6000, 12'h000, 64'h1111_2222_3333_4444, 2'd2, 1'b1,1'b0,1'b0,1'b0, 2'd3},
    '{64'h7000, 12'h010, 64'h9999_8888_7777_BEEF, 2'd1, 1'b0,1'b1,1'b1,1'b1, 2'd2},
    '{64'h7002, 12'h000, 64'h0000_0000_0000_00AA, 2'd0, 1'b1,1'b0,1'b1,1'b0, 2'd3},
    '{64'h7003, 12'h000, 64'h0000_0000_0000_BBBB, 2'd1, 1'b1,1'b0,1'b1,1'b0, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_ready;
  logic [63:0] base = '0, src = '0;
  logic [11:0] imm = '0;
  logic [1:0]  width = '0;
  logic acq = 1'b0, rel = 1'b0, cond = 1'b0;
  logic wr_valid, wr_ready = 1'b0, wr_err = 1'b0;
  logic [63:0] wr_addr, wr_data, trap_tval, redirect_pc;
  logic [1:0]  wr_size;
  logic [2:0]  wr_kind;
  logic trap, done, unsup;
  logic [4:0] trap_cause;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  store_fault_unit #(.XLEN(64), .TRAP_VEC(TVEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_ready_o(op_ready),
    .base_i(base), .imm_i(imm), .src_i(src), .width_i(width),
    .acq_i(acq), .rel_i(rel), .cond_i(cond),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_err_i(wr_err),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_size_o(wr_size), .wr_kind_o(wr_kind),
    .trap_o(trap), .trap_cause_o(trap_cause), .trap_tval_o(trap_tval),
    .redirect_pc_o(redirect_pc), .done_o(done), .unsup_o(unsup)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_kind(input logic a, input logic r, input logic c);
    case ({c, a, r})
      3'b001:  return 3'd1;
      3'b011:  return 3'd2;
      3'b100:  return 3'd3;
      3'b101:  return 3'd4;
      3'b111:  return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input string tag);
    logic [63:0] ea, ed;
    logic [1:0] got;
    bit seen, have;
    int stall;
    logic [63:0] first_addr, first_data;
    ea = v.base + {{52{v.imm[11]}}, v.imm};
    case (v.w)
      2'd0:    ed = {56'd0, v.src[7:0]};
      2'd1:    ed = {48'd0, v.src[15:0]};
      2'd2:    ed = {32'd0, v.src[31:0]};
      default: ed = v.src;
    endcase
    base = v.base; imm = v.imm; src = v.src; width = v.w;
    acq = v.acq; rel = v.rel; cond = v.cond; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    seen = 1'b0; have = 1'b0; stall = 0; got = O_DONE;
    first_addr = '0; first_data = '0;
    for (int c = 0; c < 16 && !have; c++) begin
      if (trap) begin
        have = 1'b1;
        got = (trap_cause == 5'd6) ? O_MIS : O_ACC;
        check(trap_tval == ea, {tag, " R4/R7 tval"}, trap_tval, ea);
        check(redirect_pc == TVEC, {tag, " R9 redirect"}, redirect_pc, TVEC);
      end else if (done) begin
        have = 1'b1; got = O_DONE;
      end else if (unsup) begin
        have = 1'b1; got = O_UNS;
      end else if (wr_valid) begin
        if (!seen) begin
          seen = 1'b1; first_addr = wr_addr; first_data = wr_data;
          check(wr_addr == ea, {tag, " R1 addr"}, wr_addr, ea);
          check(wr_data == ed, {tag, " R2 data"}, wr_data, ed);
          check(wr_size == v.w, {tag, " R2 size"}, {62'd0, wr_size}, {62'd0, v.w});
          check(wr_kind == exp_kind(v.acq, v.rel, v.cond), {tag, " R3 kind"},
                {61'd0, wr_kind}, {61'd0, exp_kind(v.acq, v.rel, v.cond)});
          check(!op_ready, {tag, " R11 busy"}, {63'd0, op_ready}, 64'd0);
        end else begin
          check(wr_addr == first_addr && wr_data == first_data, {tag, " R8 hold"},
                wr_addr, first_addr);
        end
        stall++;
        if (stall == 3) begin wr_ready = 1'b1; wr_err = v.merr; end
      end
      @(negedge clk);
      wr_ready = 1'b0; wr_err = 1'b0;
    end
    check(have && got == v.outc, {tag, " R4/R5/R6/R7/R9 outcome"}, {62'd0, got}, {62'd0, v.outc});
    check(seen == (v.outc == O_DONE || v.outc == O_ACC), {tag, " R4/R6 write issued"},
          {63'd0, seen}, {63'd0, (v.outc == O_DONE || v.outc == O_ACC)});
    check(op_ready && !trap && !done && !unsup, {tag, " R9 single pulse"},
          {60'd0, op_ready, trap, done, unsup}, 64'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(op_ready == 1'b1, "R10 ready", {63'd0, op_ready}, 64'd1);
    check(!wr_valid && !trap && !done && !unsup, "R10 outputs low",
          {60'd0, wr_valid, trap, done, unsup}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], $sformatf("vec%0d", i));
    // R5 doubleword plain store at odd address goes through
    run_vec('{64'h8000, 12'h003, 64'hDEAD_0000_BEEF_1111, 2'd3, 1'b0,1'b0,1'b0,1'b0, O_DONE}, "R5 dir");
    // R4 ordered halfword, negative offset reaching odd address
    run_vec('{64'h9000, 12'hFFF, 64'h1234, 2'd1, 1'b0,1'b0,1'b1,1'b0, O_MIS}, "R4 dir");
    // R7 plain store rejected by memory
    run_vec('{64'hA000, 12'h004, 64'h77, 2'd0, 1'b0,1'b0,1'b0,1'b1, O_ACC}, "R7 dir");
    // R10 reset mid-write clears pending request
    base = 64'hB000; imm = '0; src = 64'h1; width = 2'd3;
    acq = 1'b0; rel = 1'b0; cond = 1'b0; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check(wr_valid, "R10 write pending before reset", {63'd0, wr_valid}, 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    check(!wr_valid && op_ready, "R10 reset clears", {62'd0, wr_valid, op_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule